// File: doc/BRIEF.md
# Peripheral Idle Timeout Timer

This block watches the I/O bus for activity on two peripheral channels, a hard disk and a floppy drive, so that power management can switch an unused drive off. Each channel owns a 16-bit down counter clocked by a once-per-second tick. An access to either of the channel's two data port addresses refills the counter from that channel's programmed reload value. If the counter runs down to zero, the block requests a system management interrupt (SMI) and records the event in a per-channel status bit and in a shared summary bit.

Software programs a reload value and sets an enable bit for each channel. A rising enable, or a strobe that reports a write to the reload value, loads the counter. The interrupt handler reads the per-channel status, which clears it. An expired counter stays at zero and raises no further interrupts until it is refilled. A reload value of zero keeps the channel quiet.

Top module: `periph_idle_watch`

## Requirements
- R1: While reset is low and in the first cycle after reset, `smi_req`, `top_status` and `chan_status` are 0 and every counter is 0.
- R2: A rising edge on `chan_en[i]` loads channel i's counter from its reload value. Channel 0 is the disk and channel 1 is the floppy.
- R3: An enabled channel with a non-zero count decrements once for each clock cycle in which `sec_tick` is high. After N ticks with no refill from a reload value N, the channel expires on the edge that samples the N-th tick.
- R4: A cycle with `io_strobe` high and `io_addr` equal to 16'h01F0 or 16'h03F6 refills the disk counter. Any other address leaves it unchanged.
- R5: A cycle with `io_strobe` high and `io_addr` equal to 16'h03F5 or 16'h0375 refills the floppy counter. Any other address leaves it unchanged.
- R6: A pulse on `chan_load[i]` refills channel i's counter from its reload value. A refill takes priority over a tick in the same cycle.
- R7: An expiry sets `chan_status[0]` (disk) or `chan_status[1]` (floppy). `top_status` is the OR of the two status bits.
- R8: `smi_req` is high for exactly the one cycle that follows an expiring edge.
- R9: An expiry happens once. The counter then stays at zero and raises no further SMI until it is refilled.
- R10: A channel whose reload value is 0, or whose enable is low, never expires. A disabled channel holds its count.
- R11: `stat_rd` clears every status bit at the next edge. An expiry on that same edge still leaves its own bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_strobe | input | 1 | I/O access is valid this cycle |
| io_addr | input | 16 | I/O port address of the access |
| sec_tick | input | 1 | One-cycle pulse once per second |
| chan_en | input | 2 | Per-channel enable (bit 0 disk, bit 1 floppy) |
| chan_load | input | 2 | Per-channel refill strobe (reload value written) |
| disk_reload | input | 16 | Disk reload value in seconds |
| flop_reload | input | 16 | Floppy reload value in seconds |
| stat_rd | input | 1 | Read of the per-channel status, clears it |
| smi_req | output | 1 | One-cycle SMI request |
| top_status | output | 1 | Summary status, OR of the channel bits |
| chan_status | output | 2 | Per-channel expiry status |

## Verification
A corrupted counter shows up only when the channel reaches zero. A count that is too large or too small moves the status rise and the SMI pulse away from the tick in which the bench expects them. Small reload values keep that delay within a few ticks. A wrong address compare or a wrong refill priority shows the same way, as an expiry that comes early or late. A stuck status flop appears one cycle after a read, as a bit that fails to clear or a summary bit that disagrees with it.

// File: rtl/idle_pkg.sv
package idle_pkg;
    localparam int NCH = 2;   // disk, floppy
    localparam int AW  = 16;
    localparam int CW  = 16;
    localparam int PPC = 2;   // data ports watched per channel

    // Watched data port k of channel ch
    function automatic logic [AW-1:0] chan_port(input int ch, input int k);
        logic [AW-1:0] p;
        case (ch)
            0:       p = (k == 0) ? 16'h01F0 : 16'h03F6;
            default: p = (k == 0) ? 16'h03F5 : 16'h0375;
        endcase
        return p;
    endfunction
endpackage

// File: rtl/port_match.sv
module port_match #(
    parameter int AW  = 16,
    parameter int PPC = 2,
    parameter logic [PPC*AW-1:0] PORTS = '0
) (
    input  logic [AW-1:0] addr,
    output logic          match
);
    logic [PPC-1:0] hit_vec;

    for (genvar k = 0; k < PPC; k++) begin : g_cmp
        assign hit_vec[k] = (addr == PORTS[k*AW +: AW]);
    end

    assign match = |hit_vec;
endmodule

// File: rtl/idle_counter.sv
module idle_counter #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          tick,
    input  logic          hit,
    input  logic          load,
    input  logic [CW-1:0] reload,
    output logic [CW-1:0] cnt,
    output logic          expire
);
    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          en_prev;
    } ctr_t;

    ctr_t st_d, st_q;
    logic en_rise;
    logic refill;

    always_comb begin
        st_d         = st_q;
        st_d.en_prev = en;
        en_rise      = en && !st_q.en_prev;
        refill       = en_rise || hit || load;
        expire       = 1'b0;
        if (refill) begin
            st_d.cnt = reload;
        end else if (en && tick && (st_q.cnt != '0)) begin
            st_d.cnt = st_q.cnt - CW'(1);
            expire   = (st_q.cnt == CW'(1));
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt = st_q.cnt;
endmodule

// File: rtl/smi_status.sv
module smi_status #(
    parameter int NCH = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] expire,
    input  logic           rd_clr,
    output logic [NCH-1:0] stat,
    output logic           summary,
    output logic           smi
);
    typedef struct packed {
        logic [NCH-1:0] stat;
        logic           smi;
    } stat_t;

    stat_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.stat = (rd_clr ? '0 : st_q.stat) | expire;
        st_d.smi  = |expire;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign stat    = st_q.stat;
    assign summary = |st_q.stat;
    assign smi     = st_q.smi;
endmodule

// File: rtl/periph_idle_watch.sv
module periph_idle_watch
    import idle_pkg::*;
#(
    parameter int ADDR_W = idle_pkg::AW,
    parameter int CNT_W  = idle_pkg::CW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              io_strobe,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              sec_tick,
    input  logic [1:0]        chan_en,
    input  logic [1:0]        chan_load,
    input  logic [CNT_W-1:0]  disk_reload,
    input  logic [CNT_W-1:0]  flop_reload,
    input  logic              stat_rd,
    output logic              smi_req,
    output logic              top_status,
    output logic [1:0]        chan_status
);
    localparam int NC = NCH;

    logic [CNT_W-1:0] reload_arr [NC];
    logic [CNT_W-1:0] cnt_arr    [NC];
    logic [NC-1:0]    port_hit;
    logic [NC-1:0]    expire;

    assign reload_arr[0] = disk_reload;
    assign reload_arr[1] = flop_reload;

    for (genvar ch = 0; ch < NC; ch++) begin : g_chan
        logic addr_match;

        port_match #(
            .AW   (ADDR_W),
            .PPC  (PPC),
            .PORTS({chan_port(ch, 1), chan_port(ch, 0)})
        ) u_match (
            .addr (io_addr),
            .match(addr_match)
        );

        assign port_hit[ch] = io_strobe && addr_match;

        idle_counter #(.CW(CNT_W)) u_ctr (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (chan_en[ch]),
            .tick  (sec_tick),
            .hit   (port_hit[ch]),
            .load  (chan_load[ch]),
            .reload(reload_arr[ch]),
            .cnt   (cnt_arr[ch]),
            .expire(expire[ch])
        );
    end

    smi_status #(.NCH(NC)) u_stat (
        .clk    (clk),
        .rst_n  (rst_n),
        .expire (expire),
        .rd_clr (stat_rd),
        .stat   (chan_status),
        .summary(top_status),
        .smi    (smi_req)
    );
endmodule

// File: rtl/idle_watch_chk.sv
module idle_watch_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             io_strobe,
    input logic             sec_tick,
    input logic [1:0]       chan_en,
    input logic [1:0]       chan_load,
    input logic             stat_rd,
    input logic             smi_req,
    input logic             top_status,
    input logic [1:0]       chan_status,
    input logic [CNT_W-1:0] disk_cnt
);
    // R7: an SMI pulse always comes with a summary status bit
    p_smi_status_r7: assert property (@(posedge clk) disable iff (!rst_n)
        smi_req |-> top_status);

    // R8: a new status bit always comes with an SMI pulse
    p_rise_smi_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_status != 2'b00) && ($past(chan_status) == 2'b00) |-> smi_req);

    // R3: an expiry is only caused by a second tick
    p_smi_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
        smi_req |-> $past(sec_tick));

    // R11: a read clears status unless a new expiry lands on it
    p_read_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        stat_rd |=> (smi_req || (chan_status == 2'b00)));

    // R10: a disabled disk channel with no refill holds its count
    p_hold_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!chan_en[0] && !chan_load[0] && !io_strobe) |=> $stable(disk_cnt));
endmodule

bind periph_idle_watch idle_watch_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .io_strobe  (io_strobe),
    .sec_tick   (sec_tick),
    .chan_en    (chan_en),
    .chan_load  (chan_load),
    .stat_rd    (stat_rd),
    .smi_req    (smi_req),
    .top_status (top_status),
    .chan_status(chan_status),
    .disk_cnt   (cnt_arr[0])
);

// File: tb/sim_periph_idle_watch.sv
module sim_periph_idle_watch;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        io_strobe = 1'b0;
    logic [15:0] io_addr = 16'h0;
    logic        sec_tick = 1'b0;
    logic [1:0]  chan_en = 2'b00;
    logic [1:0]  chan_load = 2'b00;
    logic [15:0] disk_reload = 16'h0;
    logic [15:0] flop_reload = 16'h0;
    logic        stat_rd = 1'b0;
    logic        smi_req;
    logic        top_status;
    logic [1:0]  chan_status;

    int checks = 0;
    int errors = 0;
    string tag = "R1";

    // requirement-level model
    logic [15:0] m_cnt [2];
    logic [1:0]  m_enp = 2'b00;
    logic [1:0]  m_stat = 2'b00;
    logic        m_smi = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    periph_idle_watch u0 (
        .clk(clk), .rst_n(rst_n), .io_strobe(io_strobe), .io_addr(io_addr),
        .sec_tick(sec_tick), .chan_en(chan_en), .chan_load(chan_load),
        .disk_reload(disk_reload), .flop_reload(flop_reload), .stat_rd(stat_rd),
        .smi_req(smi_req), .top_status(top_status), .chan_status(chan_status)
    );

    function automatic bit port_of(input int ch, input logic [15:0] a);
        if (ch == 0) return (a == 16'h01F0) || (a == 16'h03F6);
        return (a == 16'h03F5) || (a == 16'h0375);
    endfunction

    task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s {smi,top,stat} actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    // one clock: apply inputs, advance model, compare after the edge
    task automatic cyc(input bit stb, input logic [15:0] a, input bit tk,
                       input logic [1:0] en, input logic [1:0] ld, input bit rd);
        logic [15:0] rel;
        logic [1:0]  fire;
        io_strobe = stb; io_addr = a; sec_tick = tk;
        chan_en = en; chan_load = ld; stat_rd = rd;
        fire = 2'b00;
        for (int ch = 0; ch < 2; ch++) begin
            rel = (ch == 0) ? disk_reload : flop_reload;
            if ((en[ch] && !m_enp[ch]) || (stb && port_of(ch, a)) || ld[ch])
                m_cnt[ch] = rel;
            else if (en[ch] && tk && m_cnt[ch] != 16'h0) begin
                fire[ch]  = (m_cnt[ch] == 16'h1);
                m_cnt[ch] = m_cnt[ch] - 16'h1;
            end
        end
        m_enp  = en;
        m_stat = (rd ? 2'b00 : m_stat) | fire;
        m_smi  = |fire;
        @(posedge clk);
        @(negedge clk);
        check(tag, {smi_req, top_status, chan_status}, {m_smi, |m_stat, m_stat});
    endtask

    task automatic idle(input int n, input bit tk, input logic [1:0] en);
        for (int i = 0; i < n; i++) cyc(1'b0, 16'h0, tk, en, 2'b00, 1'b0);
    endtask

    initial begin
        #(8 * 190000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        m_cnt[0] = 16'h0; m_cnt[1] = 16'h0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", {smi_req, top_status, chan_status}, 4'b0000);
        rst_n = 1'b1;
        idle(2, 1'b1, 2'b00);   // R1: nothing happens after reset

        // R2 R3 R7 R8: enable loads 3, third tick expires the disk channel
        tag = "R2 R3"; disk_reload = 16'd3;
        cyc(1'b0, 16'h0, 1'b0, 2'b01, 2'b00, 1'b0);
        idle(2, 1'b1, 2'b01);
        check("R3", {smi_req, top_status, chan_status}, 4'b0000);
        cyc(1'b0, 16'h0, 1'b1, 2'b01, 2'b00, 1'b0);
        check("R7 R8", {smi_req, top_status, chan_status}, 4'b1101);
        idle(1, 1'b0, 2'b01);
        check("R8", {smi_req, top_status, chan_status}, 4'b0101);

        // R9: stays at zero, no repeat; R11 read clears
        tag = "R9"; idle(4, 1'b1, 2'b01);
        tag = "R11"; cyc(1'b0, 16'h0, 1'b0, 2'b01, 2'b00, 1'b1);
        check("R11", {smi_req, top_status, chan_status}, 4'b0000);
        tag = "R9"; idle(3, 1'b1, 2'b01);

        // R4: near miss does nothing, matching ports refill
        tag = "R4";
        cyc(1'b1, 16'h01F1, 1'b1, 2'b01, 2'b00, 1'b0);
        idle(3, 1'b1, 2'b01);
        cyc(1'b1, 16'h01F0, 1'b0, 2'b01, 2'b00, 1'b0);
        idle(2, 1'b1, 2'b01);
        cyc(1'b1, 16'h03F6, 1'b1, 2'b01, 2'b00, 1'b0);
        idle(2, 1'b1, 2'b01);
        check("R4", {smi_req, top_status, chan_status}, 4'b0000);
        idle(1, 1'b1, 2'b01);
        check("R4", {smi_req, top_status, chan_status}, 4'b1101);
        cyc(1'b0, 16'h0, 1'b0, 2'b01, 2'b00, 1'b1);

        // R5: floppy ports
        tag = "R5"; flop_reload = 16'd2;
        cyc(1'b0, 16'h0, 1'b0, 2'b11, 2'b00, 1'b0);
        cyc(1'b1, 16'h03F5, 1'b1, 2'b11, 2'b00, 1'b0);
        idle(1, 1'b1, 2'b11);
        cyc(1'b1, 16'h0375, 1'b1, 2'b11, 2'b00, 1'b0);
        cyc(1'b1, 16'h0376, 1'b1, 2'b11, 2'b00, 1'b0);
        check("R5", {smi_req, top_status, chan_status}, 4'b0000);
        idle(1, 1'b1, 2'b11);
        check("R5", {smi_req, top_status, chan_status}, 4'b1110);

        // R11: expiry on the read edge keeps its bit
        tag = "R11"; disk_reload = 16'd1;
        cyc(1'b0, 16'h0, 1'b0, 2'b11, 2'b01, 1'b0);
        cyc(1'b0, 16'h0, 1'b1, 2'b11, 2'b00, 1'b1);
        check("R11", {smi_req, top_status, chan_status}, 4'b1101);
        cyc(1'b0, 16'h0, 1'b0, 2'b11, 2'b00, 1'b1);

        // R6: load strobe refill beats a tick
        tag = "R6"; disk_reload = 16'd2;
        cyc(1'b0, 16'h0, 1'b1, 2'b11, 2'b01, 1'b0);
        idle(1, 1'b1, 2'b11);
        cyc(1'b0, 16'h0, 1'b1, 2'b11, 2'b01, 1'b0);
        idle(1, 1'b1, 2'b11);
        check("R6", {smi_req, top_status, chan_status}, 4'b0000);
        idle(1, 1'b1, 2'b11);
        check("R6", {smi_req, top_status, chan_status}, 4'b1101);
        cyc(1'b0, 16'h0, 1'b0, 2'b11, 2'b00, 1'b1);

        // R10: zero reload never fires; disabled channel holds its count
        tag = "R10"; disk_reload = 16'd0;
        cyc(1'b0, 16'h0, 1'b0, 2'b10, 2'b01, 1'b0);
        idle(5, 1'b1, 2'b10);
        check("R10", {smi_req, top_status, chan_status}, 4'b0000);
        disk_reload = 16'd2; flop_reload = 16'd2;
        cyc(1'b0, 16'h0, 1'b0, 2'b00, 2'b11, 1'b0);
        idle(6, 1'b1, 2'b00);
        check("R10", {smi_req, top_status, chan_status}, 4'b0000);

        // random mix: R3 R4 R5 R7 R9 R11 against the model
        tag = "R3 R4 R5 R7 R11";
        void'($urandom(32'd1234));
        for (int i = 0; i < 4000; i++) begin
            logic [15:0] a;
            logic [1:0]  en;
            logic [1:0]  ld;
            case ($urandom % 8)
                0: a = 16'h01F0; 1: a = 16'h03F6; 2: a = 16'h03F5; 3: a = 16'h0375;
                4: a = 16'h01F1; 5: a = 16'h03F7; 6: a = 16'h0374;
                default: a = 16'($urandom);
            endcase
            if ($urandom % 64 == 0) disk_reload = 16'($urandom % 6);
            if ($urandom % 64 == 0) flop_reload = 16'($urandom % 6);
            en = chan_en;
            if ($urandom % 50 == 0) en[0] = ~en[0];
            if ($urandom % 50 == 0) en[1] = ~en[1];
            ld = 2'($urandom % 40 == 0 ? ($urandom % 4) : 0);
            cyc(($urandom % 8) == 0, a, ($urandom % 3) == 0, en, ld, ($urandom % 10) == 0);
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule